// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit sits next to a block of calendar counters and raises an alarm when the running time reaches a programmed moment. Software programs eight alarm fields: second, minute, hour, day of month, day of week, day of year, month and year. It also programs an eight-bit exclusion mask. Each mask bit removes one field from the comparison. This lets a single alarm fire every minute, every day, or once a year, depending on which fields take part.

The counters are outside the block. They arrive as inputs together with a one-cycle `tick` strobe, which the counter block raises once the fields have taken their new value. On each tick the unit compares every field that is not excluded. When all of them agree, it latches an alarm flag. A second flag records counter-increment events. Software reads both flags from a status word and clears each one by writing 1 to its bit. The interrupt line is high whenever either flag is set.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, every alarm field reads 0, the mask (address 0x10) reads 0xFF, the status word (address 0x00) reads 0 and `irq` is low.
- R2: The alarm fields sit at byte addresses 0x60 (second, 6 bits), 0x64 (minute, 6 bits), 0x68 (hour, 5 bits), 0x6C (day of month, 5 bits), 0x70 (day of week, 3 bits), 0x74 (day of year, 9 bits), 0x78 (month, 4 bits) and 0x7C (year, 12 bits). A write keeps only the low bits of each field's width, and a read returns them zero-extended. The mask at 0x10 holds 8 bits.
- R3: On a cycle with `tick` high and a mask other than 0xFF, if every field not excluded equals its alarm value, then status bit 1 (alarm) reads 1 from the next cycle on.
- R4: Mask bit i excludes field i from the compare. Bit 0 is second, then minute, hour, day of month, day of week, day of year, month, and bit 7 is year. A mismatch in an excluded field does not block the alarm.
- R5: A mask of 0xFF disables matching: a tick never sets the alarm flag, even when every field is equal.
- R6: Without `tick`, matching fields never set the alarm flag.
- R7: A one-cycle pulse on `incrEvent` sets status bit 0 (increment) in the next cycle.
- R8: Writing the status word clears each flag whose bit in the written data is 1 and leaves the flags written with 0 unchanged.
- R9: If a status write clears the alarm flag in the same cycle as a tick that matches, the alarm flag stays set.
- R10: `irq` is high exactly when at least one of the two status flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address for register read and write |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| tick | input | 1 | Counters updated this cycle; evaluate the compare |
| incrEvent | input | 1 | Counter-increment event pulse |
| curSec | input | 6 | Current second |
| curMin | input | 6 | Current minute |
| curHour | input | 5 | Current hour |
| curDom | input | 5 | Current day of month |
| curDow | input | 3 | Current day of week |
| curDoy | input | 9 | Current day of year |
| curMon | input | 4 | Current month |
| curYear | input | 12 | Current year |
| irq | output | 1 | Interrupt, OR of the two status flags |

## Verification
The one collision that matters is a software clear of the alarm flag landing in the same clock as a matching tick. The bench provokes it by raising `tick` with all unmasked fields equal while a write of 2 goes to the status word. It expects the flag to read back as set afterwards. The bench also raises an increment pulse and a matching tick together, and expects both status bits and `irq` to be set.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int FIELD_CNT   = 8;
  localparam int FIELD_MAX_W = 12;
  localparam int IDX_W       = $clog2(FIELD_CNT);

  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOM_W  = 5;
  localparam int DOW_W  = 3;
  localparam int DOY_W  = 9;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 12;

  localparam logic [7:0] ADDR_FLAGS      = 8'h00;
  localparam logic [7:0] ADDR_MASK       = 8'h10;
  localparam logic [7:0] ADDR_ALARM_BASE = 8'h60;

  localparam int FLAG_INCR_BIT  = 0;
  localparam int FLAG_ALARM_BIT = 1;

  function automatic int fieldWidth(int idx);
    case (idx)
      0: return SEC_W;
      1: return MIN_W;
      2: return HOUR_W;
      3: return DOM_W;
      4: return DOW_W;
      5: return DOY_W;
      6: return MON_W;
      default: return YEAR_W;
    endcase
  endfunction

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_FLAGS = 2'd1,
    RD_MASK  = 2'd2,
    RD_ALARM = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [FIELD_CNT-1:0] alarmWr;
    logic                 maskWr;
    logic                 flagWr;
    rdSel_e               rdSel;
    logic [IDX_W-1:0]     rdIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobes_t      strobes
);

  localparam int SPAN = 4 * FIELD_CNT;
  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(ADDR_ALARM_BASE);
  localparam logic [ADDR_W-1:0] FLAGS = ADDR_W'(ADDR_FLAGS);
  localparam logic [ADDR_W-1:0] MASKA = ADDR_W'(ADDR_MASK);

  logic [ADDR_W-1:0] offset;
  logic              inAlarm;
  logic [IDX_W-1:0]  fieldIdx;

  assign offset   = regAddr - BASE;
  assign inAlarm  = (regAddr >= BASE) && (32'(offset) < SPAN) && (regAddr[1:0] == 2'b00);
  assign fieldIdx = offset[IDX_W+1:2];

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_wr
    assign strobes.alarmWr[i] = regWrEn && inAlarm && (32'(fieldIdx) == i);
  end

  assign strobes.maskWr = regWrEn && (regAddr == MASKA);
  assign strobes.flagWr = regWrEn && (regAddr == FLAGS);
  assign strobes.rdIdx  = fieldIdx;

  always_comb begin
    if (regAddr == FLAGS)      strobes.rdSel = RD_FLAGS;
    else if (regAddr == MASKA) strobes.rdSel = RD_MASK;
    else if (inAlarm)          strobes.rdSel = RD_ALARM;
    else                       strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/cal_alarm_datapath.sv
module cal_alarm_datapath
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctrlStrobes_t                          strobes,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic                                  tick,
  input  logic                                  incrEvent,
  input  logic [FIELD_CNT-1:0][FIELD_MAX_W-1:0] curTime,
  output logic [DATA_W-1:0]                     rdData,
  output logic                                  alarmFlag,
  output logic                                  incrFlag,
  output logic                                  hitNow,
  output logic [FIELD_CNT-1:0]                  maskVal
);

  logic [FIELD_MAX_W-1:0] alarmReg [FIELD_CNT];
  logic [FIELD_CNT-1:0]   fieldOk;

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_field
    localparam int W = fieldWidth(i);
    localparam logic [FIELD_MAX_W-1:0] WMASK = FIELD_MAX_W'((64'd1 << W) - 64'd1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   alarmReg[i] <= '0;
      else if (strobes.alarmWr[i]) alarmReg[i] <= wrData[FIELD_MAX_W-1:0] & WMASK;
    end

    assign fieldOk[i] = maskVal[i] || (alarmReg[i] == curTime[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskVal <= '1;
    else if (strobes.maskWr) maskVal <= wrData[FIELD_CNT-1:0];
  end

  assign hitNow = (&fieldOk) && (maskVal != '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      incrFlag  <= 1'b0;
    end else begin
      if (tick && hitNow)                              alarmFlag <= 1'b1;
      else if (strobes.flagWr && wrData[FLAG_ALARM_BIT]) alarmFlag <= 1'b0;
      if (incrEvent)                                   incrFlag <= 1'b1;
      else if (strobes.flagWr && wrData[FLAG_INCR_BIT])  incrFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      RD_FLAGS: begin
        rdData[FLAG_ALARM_BIT] = alarmFlag;
        rdData[FLAG_INCR_BIT]  = incrFlag;
      end
      RD_MASK:  rdData = DATA_W'(maskVal);
      RD_ALARM: rdData = DATA_W'(alarmReg[strobes.rdIdx]);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tick,
  input  logic              incrEvent,
  input  logic [SEC_W-1:0]  curSec,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DOM_W-1:0]  curDom,
  input  logic [DOW_W-1:0]  curDow,
  input  logic [DOY_W-1:0]  curDoy,
  input  logic [MON_W-1:0]  curMon,
  input  logic [YEAR_W-1:0] curYear,
  output logic              irq
);

  ctrlStrobes_t                          strobes;
  logic [FIELD_CNT-1:0][FIELD_MAX_W-1:0] curTime;
  logic                                  alarmFlag;
  logic                                  incrFlag;
  logic                                  hitNow;
  logic [FIELD_CNT-1:0]                  maskVal;

  assign curTime[0] = FIELD_MAX_W'(curSec);
  assign curTime[1] = FIELD_MAX_W'(curMin);
  assign curTime[2] = FIELD_MAX_W'(curHour);
  assign curTime[3] = FIELD_MAX_W'(curDom);
  assign curTime[4] = FIELD_MAX_W'(curDow);
  assign curTime[5] = FIELD_MAX_W'(curDoy);
  assign curTime[6] = FIELD_MAX_W'(curMon);
  assign curTime[7] = FIELD_MAX_W'(curYear);

  cal_alarm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  cal_alarm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .tick      (tick),
    .incrEvent (incrEvent),
    .curTime   (curTime),
    .rdData    (regRdData),
    .alarmFlag (alarmFlag),
    .incrFlag  (incrFlag),
    .hitNow    (hitNow),
    .maskVal   (maskVal)
  );

  assign irq = alarmFlag || incrFlag;

endmodule

// File: rtl/cal_alarm_checker.sv
module cal_alarm_checker
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic                 tick,
  input logic                 incrEvent,
  input logic                 irq,
  input logic                 alarmFlag,
  input logic                 incrFlag,
  input logic                 hitNow,
  input logic [FIELD_CNT-1:0] maskVal
);

  localparam logic [ADDR_W-1:0] FLAGS = ADDR_W'(ADDR_FLAGS);

  AST_READ_IRQ_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == FLAGS) |-> (irq == (regRdData[1] || regRdData[0]))); // R10

  AST_ALARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !alarmFlag) |=> !alarmFlag); // R6

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (tick && hitNow) |=> alarmFlag); // R9

  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (maskVal == '1) |-> !hitNow); // R5

  AST_W1C_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == FLAGS && regWrData[1] && !tick) |=> !alarmFlag); // R8

  AST_INCR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    incrEvent |=> incrFlag); // R7

endmodule

bind cal_alarm_top cal_alarm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .tick      (tick),
  .incrEvent (incrEvent),
  .irq       (irq),
  .alarmFlag (alarmFlag),
  .incrFlag  (incrFlag),
  .hitNow    (hitNow),
  .maskVal   (maskVal)
);

// File: tb/cal_alarm_top_tb.sv
module cal_alarm_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        tick = 1'b0;
  logic        incrEvent = 1'b0;
  logic [5:0]  curSec = '0;
  logic [5:0]  curMin = '0;
  logic [4:0]  curHour = '0;
  logic [4:0]  curDom = '0;
  logic [2:0]  curDow = '0;
  logic [8:0]  curDoy = '0;
  logic [3:0]  curMon = '0;
  logic [11:0] curYear = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit probe = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] expData;
    logic        expIrq;
    string       tag;
  } sbItem_t;

  sbItem_t sbq[$];

  always #4 clk = ~clk;

  cal_alarm_top u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .tick(tick),
    .incrEvent(incrEvent), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDom(curDom), .curDow(curDow), .curDoy(curDoy),
    .curMon(curMon), .curYear(curYear), .irq(irq)
  );

  // Monitor: pops one expected item per probed cycle, samples at negedge
  always @(negedge clk) begin
    if (probe) begin
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: probe with empty queue");
      end else begin
        sbItem_t it;
        it = sbq.pop_front();
        checks++;
        if (regRdData !== it.expData || irq !== it.expIrq) begin
          errors++;
          $display("FAIL %s: addr=%h data=%h irq=%b expected data=%h irq=%b",
                   it.tag, regAddr, regRdData, irq, it.expData, it.expIrq);
        end
      end
    end
  end

  task automatic readCheck(input logic [7:0] a, input logic [31:0] d,
                           input logic ir, input string tag);
    sbItem_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.expData = d; it.expIrq = ir; it.tag = tag;
    sbq.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic tk, input logic inc);
    @(posedge clk); #1;
    tick = tk; incrEvent = inc;
    @(posedge clk); #1;
    tick = 1'b0; incrEvent = 1'b0;
  endtask

  task automatic clearWithTick(input logic [31:0] d);
    @(posedge clk); #1;
    regAddr = 8'h00; regWrData = d; regWrEn = 1'b1; tick = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; tick = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset values
    readCheck(8'h10, 32'hFF, 1'b0, "R1 mask reset");
    readCheck(8'h60, 32'h0, 1'b0, "R1 second alarm reset");
    readCheck(8'h7C, 32'h0, 1'b0, "R1 year alarm reset");
    readCheck(8'h00, 32'h0, 1'b0, "R1 status reset");

    // R2: program alarm fields, check truncation and readback
    writeReg(8'h60, 32'd30);
    writeReg(8'h64, 32'hFF);
    readCheck(8'h64, 32'h3F, 1'b0, "R2 minute truncated to 6 bits");
    writeReg(8'h64, 32'd15);
    writeReg(8'h68, 32'd10);
    writeReg(8'h6C, 32'd5);
    writeReg(8'h70, 32'hF3);
    readCheck(8'h70, 32'd3, 1'b0, "R2 day of week truncated to 3 bits");
    writeReg(8'h74, 32'd100);
    writeReg(8'h78, 32'd4);
    writeReg(8'h7C, 32'd2020);
    readCheck(8'h60, 32'd30, 1'b0, "R2 second readback");
    readCheck(8'h74, 32'd100, 1'b0, "R2 day of year readback");
    readCheck(8'h7C, 32'd2020, 1'b0, "R2 year readback");

    @(posedge clk); #1;
    curSec = 6'd30; curMin = 6'd15; curHour = 5'd10; curDom = 5'd5;
    curDow = 3'd3; curDoy = 9'd100; curMon = 4'd4; curYear = 12'd2020;

    // R5: mask all ones disables matching
    pulse(1'b1, 1'b0);
    readCheck(8'h00, 32'h0, 1'b0, "R5 mask 0xFF blocks alarm");

    // R6: no tick, no alarm
    writeReg(8'h10, 32'h00);
    repeat (3) @(posedge clk);
    readCheck(8'h00, 32'h0, 1'b0, "R6 no tick no alarm");

    // R3 / R10: full match sets flag and irq
    pulse(1'b1, 1'b0);
    readCheck(8'h00, 32'h2, 1'b1, "R3 R10 full match sets alarm");

    // R8: write 1 to other bit leaves alarm, write bit1 clears
    writeReg(8'h00, 32'h1);
    readCheck(8'h00, 32'h2, 1'b1, "R8 writing 0 to alarm bit keeps it");
    writeReg(8'h00, 32'h2);
    readCheck(8'h00, 32'h0, 1'b0, "R8 write 1 clears alarm");

    // R3 mismatch, R4 mask bit excludes field
    @(posedge clk); #1 curSec = 6'd31;
    pulse(1'b1, 1'b0);
    readCheck(8'h00, 32'h0, 1'b0, "R3 second mismatch no alarm");
    writeReg(8'h10, 32'h01);
    pulse(1'b1, 1'b0);
    readCheck(8'h00, 32'h2, 1'b1, "R4 second excluded by mask bit 0");
    writeReg(8'h00, 32'h2);
    @(posedge clk); #1 curYear = 12'd2021;
    pulse(1'b1, 1'b0);
    readCheck(8'h00, 32'h0, 1'b0, "R4 year still compared");
    writeReg(8'h10, 32'h81);
    pulse(1'b1, 1'b0);
    readCheck(8'h00, 32'h2, 1'b1, "R4 year excluded by mask bit 7");
    readCheck(8'h10, 32'h81, 1'b1, "R2 mask readback");

    // R9: clear and matching tick in one cycle, set wins
    writeReg(8'h00, 32'h2);
    clearWithTick(32'h2);
    readCheck(8'h00, 32'h2, 1'b1, "R9 set wins over clear");
    writeReg(8'h00, 32'h2);
    readCheck(8'h00, 32'h0, 1'b0, "R8 clear after collision");

    // R7 / R10: increment flag
    pulse(1'b0, 1'b1);
    readCheck(8'h00, 32'h1, 1'b1, "R7 R10 increment flag");
    writeReg(8'h00, 32'h1);
    readCheck(8'h00, 32'h0, 1'b0, "R8 increment flag cleared");

    // Both flags together
    pulse(1'b1, 1'b1);
    readCheck(8'h00, 32'h3, 1'b1, "R7 R3 both flags");
    writeReg(8'h00, 32'h3);
    readCheck(8'h00, 32'h0, 1'b0, "R10 irq low after clearing both");

    @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule